// File: doc/BRIEF.md
# Ratio-Selectable Time-Division Multiplexed Die Link

This block carries a wide word across a narrow die-to-die lane. It time-division multiplexes the word over the lane at a fixed ratio N of 1, 2 or 4. On the transmit side, a word held for one slow system cycle is cut into N lane-wide slices. One slice leaves on every fast link-clock edge, so the link never stalls and has no handshake.

The transmit side divides the link clock by N and sends the result as a forwarded clock. The receive side shifts the slices back into a full word on the link clock. It then presents that word from a register clocked by the forwarded clock, which serves as the receive system clock.

A parameter removes the retiming stage in front of the lane register. This moves every slice one link cycle earlier. After reset, the slice counter and the divider start from zero, so the slice alignment and the word latency are fixed.

Top module: `tdm_link`

## Requirements
- R1: The ratio parameter N takes the values 1, 2 or 4, and each value is supported with the bypass both on and off.
- R2: For N of 2 or 4, fwd_clk_o is high during link cycles 0 to N/2-1 of each system cycle and low during the rest. Its rising edge coincides with the link edge that starts link cycle 0. For N = 1, fwd_clk_o is the link clock itself.
- R3: The word width is N*LANE_W. Slice k is bits [k*LANE_W +: LANE_W], and slices go out in the order k = 0 first.
- R4: Counting link edges from 0 after reset release, the lane shows slice k of word j after edge j*N+k+D. D is 0 with the bypass on and 1 with it off. A new slice appears on every link edge and the lane never pauses.
- R5: Turning the bypass on makes every slice appear exactly one link cycle earlier on lane_o than with the bypass off.
- R6: Each word appears intact and in order on rx_word_o, with none lost or repeated. Counting forwarded-clock rising edges from m = 0, word j is shown after edge m = j + L. L is 3 (bypass on) or 4 (bypass off) for N = 1, 1 or 2 for N = 2, and 1 for N = 4.
- R7: While reset is held, lane_o and rx_word_o are zero and fwd_clk_o is high for N above 1. The first word after release is slice-aligned to the first link edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_link_i | input | 1 | Fast link clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_word_i | input | N*LANE_W | Word to send; must be held for one full system cycle, changing just after each fwd_clk_o rising edge |
| lane_o | output | LANE_W | Serialized lane, one slice per link cycle |
| fwd_clk_o | output | 1 | Forwarded clock, the link clock divided by N |
| rx_word_o | output | N*LANE_W | Reassembled word, updated on fwd_clk_o rising edges |

## Verification
Each lane slice is due D link edges after the edge that starts its link cycle, where D is 0 or 1. The bench predicts the lane value for every link cycle from its stored words and samples it at the following falling edge. Reassembled words are due L forwarded-clock edges after the system cycle in which they were driven. A scoreboard queue is popped only on forwarded-clock rising edges once L edges have passed, and zero is expected before that. All six ratio and bypass combinations run side by side.

// File: rtl/tdm_link_pkg.sv
package tdm_link_pkg;
  function automatic int cnt_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // receive load phase chosen so the hold register never changes on a forwarded-clock rise
  function automatic bit rx_use_tail(int n, int fast);
    int d;
    d = fast ? 0 : 1;
    return (n > 1) && (((d + 1) % n) == n - 1);
  endfunction

  function automatic int rx_load_phase(int n, int fast);
    int d;
    d = fast ? 0 : 1;
    return rx_use_tail(n, fast) ? (d % n) : ((d + 1) % n);
  endfunction
endpackage

// File: rtl/tdm_clk_div.sv
module tdm_clk_div
  import tdm_link_pkg::*;
#(
  parameter int N = 4,
  localparam int CNT_W = cnt_w(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fwd_clk_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt = (cnt_q == CNT_W'(N - 1)) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt;

  assign cnt_o = cnt_q;

  a_r2_cnt_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(N - 1)) |=> (cnt_q == '0));

  generate
    if (N == 1) begin : g_pass
      assign fwd_clk_o = clk_i;
    end else begin : g_div
      logic fwd_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) fwd_q <= 1'b1;
        else         fwd_q <= (cnt_nxt < CNT_W'(N / 2));
      assign fwd_clk_o = fwd_q;

      a_r2_fwd_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fwd_q) |-> (cnt_q == '0));
    end
  endgenerate
endmodule

// File: rtl/tdm_tx_mux.sv
module tdm_tx_mux
  import tdm_link_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int N      = 4,
  parameter bit FAST   = 1'b0,
  localparam int CNT_W  = cnt_w(N),
  localparam int WORD_W = N * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [LANE_W-1:0] lane_o
);
  logic [LANE_W-1:0] sel, lane_q;

  assign sel = word_i[int'(cnt_i) * LANE_W +: LANE_W];

  generate
    if (FAST) begin : g_fast
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) lane_q <= '0;
        else         lane_q <= sel;
    end else begin : g_stage
      logic [LANE_W-1:0] stage_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          stage_q <= '0;
          lane_q  <= '0;
        end else begin
          stage_q <= sel;
          lane_q  <= stage_q;
        end
    end
  endgenerate

  assign lane_o = lane_q;
endmodule

// File: rtl/tdm_rx_demux.sv
module tdm_rx_demux
  import tdm_link_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int N      = 4,
  parameter bit FAST   = 1'b0,
  localparam int CNT_W  = cnt_w(N),
  localparam int WORD_W = N * LANE_W,
  localparam bit USE_TAIL = rx_use_tail(N, int'(FAST)),
  localparam int LD_PH    = rx_load_phase(N, int'(FAST))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              fwd_clk_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sh_q, sh_nxt, hold_q, word_q;
  logic ld;

  generate
    if (N == 1) begin : g_one
      assign sh_nxt = lane_i;
    end else begin : g_shift
      assign sh_nxt = {lane_i, sh_q[WORD_W-1:LANE_W]};
    end
  endgenerate

  assign ld = (cnt_i == CNT_W'(LD_PH));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sh_q   <= '0;
      hold_q <= '0;
    end else begin
      sh_q <= sh_nxt;
      if (ld) hold_q <= USE_TAIL ? sh_nxt : sh_q;
    end

  // receive system clock domain
  always_ff @(posedge fwd_clk_i or negedge rst_ni)
    if (!rst_ni) word_q <= '0;
    else         word_q <= hold_q;

  assign word_o = word_q;

  generate
    if (N > 1) begin : g_chk
      a_r6_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fwd_clk_i) |-> $stable(hold_q));
      a_r6_word_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fwd_clk_i) |-> (word_q == hold_q));
    end
  endgenerate
endmodule

// File: rtl/tdm_link.sv
module tdm_link
  import tdm_link_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int N      = 4,
  parameter bit FAST   = 1'b0,
  localparam int CNT_W  = cnt_w(N),
  localparam int WORD_W = N * LANE_W
) (
  input  logic              clk_link_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic [LANE_W-1:0] lane_o,
  output logic              fwd_clk_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic [CNT_W-1:0] cnt;

  tdm_clk_div #(.N(N)) u_div (
    .clk_i(clk_link_i), .rst_ni(rst_ni), .cnt_o(cnt), .fwd_clk_o(fwd_clk_o)
  );

  tdm_tx_mux #(.LANE_W(LANE_W), .N(N), .FAST(FAST)) u_tx (
    .clk_i(clk_link_i), .rst_ni(rst_ni), .cnt_i(cnt), .word_i(tx_word_i), .lane_o(lane_o)
  );

  tdm_rx_demux #(.LANE_W(LANE_W), .N(N), .FAST(FAST)) u_rx (
    .clk_i(clk_link_i), .rst_ni(rst_ni), .cnt_i(cnt), .fwd_clk_i(fwd_clk_o),
    .lane_i(lane_o), .word_o(rx_word_o)
  );
endmodule

// File: tb/tdm_link_tb_top.sv
module tdm_link_tb_top;
  localparam int RUN_EC = 400;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   ec = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n) ec <= ec + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int g, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cfg%0d %s: actual %0h expected %0h", req, g, what, act, exp);
    end
  endtask

  for (genvar g = 0; g < 6; g++) begin : cfg
    localparam int N    = (g / 2 == 0) ? 1 : ((g / 2 == 1) ? 2 : 4);
    localparam bit FAST = (g % 2) == 1;
    localparam int D    = FAST ? 0 : 1;
    localparam int LAT  = (N == 1) ? (FAST ? 3 : 4) : ((N == 2) ? (FAST ? 1 : 2) : 1);
    localparam int W    = N * LW;

    logic [W-1:0]  tx_word = '0;
    logic [LW-1:0] lane;
    logic          fwd;
    logic [W-1:0]  rx_word;
    logic [31:0]   words [0:511];
    logic [31:0]   sb_q [$];

    tdm_link #(.LANE_W(LW), .N(N), .FAST(FAST)) dut_i (
      .clk_link_i(clk), .rst_ni(rst_n), .tx_word_i(tx_word),
      .lane_o(lane), .fwd_clk_o(fwd), .rx_word_o(rx_word)
    );

    // R7: reset state while rst_n is low
    initial begin
      #10;
      chk(lane == '0, "R7", "lane in reset", g, 32'(lane), 32'h0);
      chk(rx_word == '0, "R7", "rx word in reset", g, 32'(rx_word), 32'h0);
      if (N > 1) chk(fwd == 1'b1, "R7", "fwd clk in reset", g, 32'(fwd), 32'h1);
    end

    always @(negedge clk) begin
      int e, j, m;
      logic [31:0] exp;
      if (rst_n && ec < RUN_EC) begin
        // R3 R4 R5: lane slice for the link cycle after edge ec-1
        if (ec >= 1 && ec - 1 >= D) begin
          e = ec - 1 - D;
          exp = (words[e / N] >> ((e % N) * LW)) & 32'hff;
          chk(32'(lane) == exp, "R3 R4 R5", "lane slice", g, 32'(lane), exp);
        end
        // R2: forwarded clock phase
        if (N > 1) begin
          exp = 32'((ec % N) < (N / 2));
          chk(32'(fwd) == exp, "R2", "fwd clk level", g, 32'(fwd), exp);
        end
        // R1 R6: scoreboard on forwarded-clock rising edges
        if (ec > 0 && ec % N == 0) begin
          m = ec / N - 1;
          if (m >= LAT) begin
            exp = sb_q.pop_front();
            chk(32'(rx_word) == exp, "R1 R6", "rx word", g, 32'(rx_word), exp);
          end else begin
            chk(rx_word == '0, "R6", "rx word before first", g, 32'(rx_word), 32'h0);
          end
        end
        // driver: new word at the start of each system cycle
        if (ec % N == 0) begin
          j = ec / N;
          tx_word = W'($urandom());
          if (j == 1) tx_word = '1;
          if (j == 2) tx_word = '0;
          words[j] = 32'(tx_word);
          sb_q.push_back(32'(tx_word));
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    wait (ec >= RUN_EC);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule